// File: doc/BRIEF.md
# Pulse-Width Single-Wire Bit Codec

This block converts bytes to and from a single-wire link on which every bit is a rising edge followed by a high time. The length of that high time, as a fraction of the bit period, carries the bit value. The originator side drives the wire. On the send path, bytes taken through a valid/ready handshake are shifted out most significant bit first. The bit period comes from a programmable count of system clocks. Each burst of back-to-back bytes begins with a timing-negotiation pulse.

The receive path watches the same wire through a synchronizer and a glitch filter. It times the negotiation pulse from one rising edge to the next and keeps that count as the bit period for the rest of the burst. It then sorts each later high time into a one or a zero against fractions of that measured period. Finished bytes appear as a one-cycle valid pulse with an error flag. Out-of-range high times and an early end of a byte are both reported through that flag.

Top module: `pwb_link`

## Requirements
- R1: A transmitted logic 1 holds `line_drv` high for floor(7·P/10) clocks of a P-clock bit period, where P is `bit_period` (legal range 20 to 2^CNT_W−1).
- R2: A transmitted logic 0 holds `line_drv` high for floor(3·P/10) clocks of the P-clock bit period.
- R3: Each burst opens with one negotiation period of P clocks, shaped as a logic 0. Bytes accepted in the last cycle of the previous byte follow with no new negotiation. P is captured when a burst starts, and changes to `bit_period` during the burst have no effect. Successive rising edges are exactly P clocks apart.
- R4: Bits travel most significant bit first in both directions.
- R5: `tx_ready` is high when the sender is idle and in the final clock of a byte's last bit. It is low at all other times while a byte is being shifted out.
- R6: The receiver stores the rise-to-rise length T of the negotiation pulse. It decodes each following bit as 1 exactly when twice its high time H exceeds T, and as 0 otherwise.
- R7: A bit with 5·H < T or 5·H > 4·T marks its byte as bad. That byte is still delivered, with `rx_err` set.
- R8: If no rising edge arrives for 2·T clocks, the receiver returns to waiting for negotiation. If a byte was partly received, it emits one `rx_valid` pulse with `rx_err`=1 and `rx_data`=0. If no byte was in progress, it emits nothing.
- R9: `line_in` passes through two synchronizer flops and a filter that drops any level lasting a single clock, so one-clock pulses never reach the decoder.
- R10: In reset, `line_drv`=0, `tx_ready`=1, `rx_valid`=0 and `rx_err`=0.
- R11: `rx_valid` is a single-cycle pulse per delivered byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bit_period | input | CNT_W | Transmit bit period in clocks, captured at burst start |
| tx_data | input | DATA_W | Byte to send |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Sender accepts `tx_data` this cycle |
| line_drv | output | 1 | 1 = drive the wire high |
| line_in | input | 1 | Sensed wire level |
| rx_data | output | DATA_W | Received byte |
| rx_valid | output | 1 | One-cycle pulse: `rx_data` and `rx_err` are valid |
| rx_err | output | 1 | Received byte had a bad bit or was cut short |

## Verification
The assertions assume that `bit_period` is at least 20 when a burst starts. Under that assumption the shortest high pulse lasts several clocks, and a byte takes far longer than one cycle to send or receive. The bench uses periods only between 20 and 64 clocks. When it drives the wire itself, every deliberate high or low level lasts at least two clocks, except for the one-clock glitches that R9 exercises. The bench holds `tx_valid` and `tx_data` steady until the sender accepts them, and it leaves the wire low for over three bit periods between frames, so each frame starts from an idle receiver.

// File: rtl/pwb_pkg.sv
// Shared types for the pulse-width bit codec.
// Assumes: nothing beyond IEEE 1800-2017 enum support.
package pwb_pkg;

    // Sender sequencing: idle, negotiation period, data bits.
    typedef enum logic [1:0] {
        TX_IDLE = 2'd0,
        TX_NEG  = 2'd1,
        TX_BIT  = 2'd2
    } tx_state_e;

    // Receiver sequencing: waiting, timing negotiation, locked on data.
    typedef enum logic [1:0] {
        RX_IDLE = 2'd0,
        RX_NEG  = 2'd1,
        RX_DATA = 2'd2
    } rx_state_e;

    // Smallest bit period (in clocks) the fraction windows resolve at.
    localparam int PWB_MIN_PERIOD = 20;

endpackage

// File: rtl/pwb_sync.sv
// Brings the asynchronous wire level into the clock domain and removes
// single-clock pulses, then reports filtered rising and falling edges.
// Assumes: SYNC_STAGES >= 2. Both edges see the same latency, so the
// width of every pulse that survives the filter is preserved.
module pwb_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic rise_o,
    output logic fall_o
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   hold_q;
    logic                   level_q;
    logic                   level_d;

    // Metastability chain on the raw pin.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], pin_i};
    end

    // Glitch filter: accept a new level only once two samples agree.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_q  <= 1'b0;
            level_q <= 1'b0;
            level_d <= 1'b0;
        end else begin
            hold_q  <= sync_q[TOP];
            level_d <= level_q;
            if (sync_q[TOP] == hold_q) level_q <= hold_q;
        end
    end

    assign rise_o = level_q & ~level_d;
    assign fall_o = ~level_q & level_d;

endmodule

// File: rtl/pwb_tx.sv
// Sender: shifts bytes MSB first as pulse-width coded bits. A burst starts
// with one negotiation period shaped as a logic 0. A byte accepted in the
// last clock of the previous one continues the burst with no gap.
// Assumes: period_i >= 20 when a burst starts; the period is captured then.
module pwb_tx
    import pwb_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  period_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              valid_i,
    output logic              ready_o,
    output logic              drive_o
);
    localparam int               IDX_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam int               MUL_W    = CNT_W + 4;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    tx_state_e         state_q;
    logic [CNT_W-1:0]  per_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] sh_q;
    logic [IDX_W-1:0]  idx_q;
    logic [MUL_W-1:0]  hi_one;
    logic [MUL_W-1:0]  hi_zero;
    logic [MUL_W-1:0]  hi_cur;
    logic              period_end;
    logic              last_bit;
    logic              take;

    // High-time targets at 7/10 and 3/10 of the captured period.
    always_comb begin
        hi_one  = (MUL_W'(per_q) * MUL_W'(7)) / MUL_W'(10);
        hi_zero = (MUL_W'(per_q) * MUL_W'(3)) / MUL_W'(10);
        hi_cur  = (state_q == TX_BIT && sh_q[DATA_W-1]) ? hi_one : hi_zero;
    end

    assign period_end = (cnt_q == per_q - CNT_W'(1));
    assign last_bit   = (idx_q == LAST_IDX);
    assign ready_o    = (state_q == TX_IDLE) ||
                        (state_q == TX_BIT && last_bit && period_end);
    assign take       = valid_i && ready_o;
    assign drive_o    = (state_q != TX_IDLE) && (MUL_W'(cnt_q) < hi_cur);

    // Burst sequencing, period counting and MSB-first shifting.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            per_q   <= '0;
            cnt_q   <= '0;
            sh_q    <= '0;
            idx_q   <= '0;
        end else begin
            unique case (state_q)
                TX_IDLE: begin
                    if (take) begin
                        per_q   <= period_i;
                        sh_q    <= data_i;
                        cnt_q   <= '0;
                        idx_q   <= '0;
                        state_q <= TX_NEG;
                    end
                end
                TX_NEG: begin
                    if (period_end) begin
                        cnt_q   <= '0;
                        state_q <= TX_BIT;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                TX_BIT: begin
                    if (period_end) begin
                        cnt_q <= '0;
                        if (last_bit) begin
                            idx_q <= '0;
                            if (take) sh_q    <= data_i;
                            else      state_q <= TX_IDLE;
                        end else begin
                            sh_q  <= {sh_q[DATA_W-2:0], 1'b0};
                            idx_q <= idx_q + IDX_W'(1);
                        end
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                default: state_q <= TX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pwb_rx.sv
// Receiver: measures the negotiation pulse rise to rise as the bit period T,
// then classifies each high time H at its falling edge (1 when 2H > T) and
// flags H outside [T/5, 4T/5]. No rising edge for 2T clocks ends the burst.
// Assumes: rise_i / fall_i come from a filtered, synchronized wire.
module pwb_rx
    import pwb_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rise_i,
    input  logic              fall_i,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              err_o
);
    localparam int               TW       = CNT_W + 1;
    localparam int               EW       = CNT_W + 4;
    localparam int               IDX_W    = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DATA_W - 1);

    rx_state_e         state_q;
    logic [TW-1:0]     cnt_q;
    logic [CNT_W-1:0]  tbit_q;
    logic [DATA_W-1:0] sh_q;
    logic [IDX_W-1:0]  idx_q;
    logic              bad_q;
    logic [EW-1:0]     hi_e;
    logic [EW-1:0]     tb_e;
    logic              bit_one;
    logic              too_short;
    logic              too_long;
    logic              timeout;

    // Threshold comparisons scaled by the measured period.
    always_comb begin
        hi_e      = EW'(cnt_q);
        tb_e      = EW'(tbit_q);
        bit_one   = (hi_e << 1) > tb_e;
        too_short = (hi_e * EW'(5)) < tb_e;
        too_long  = (hi_e * EW'(5)) > (tb_e << 2);
        timeout   = !rise_i && (cnt_q >= (TW'(tbit_q) << 1));
    end

    // Clocks since the last filtered rising edge, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (rise_i)         cnt_q <= TW'(1);
        else if (cnt_q != '1)    cnt_q <= cnt_q + TW'(1);
    end

    // Negotiation lock, bit assembly and byte delivery.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= RX_IDLE;
            tbit_q  <= '0;
            sh_q    <= '0;
            idx_q   <= '0;
            bad_q   <= 1'b0;
            data_o  <= '0;
            valid_o <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            unique case (state_q)
                RX_IDLE: begin
                    if (rise_i) state_q <= RX_NEG;
                end
                RX_NEG: begin
                    if (cnt_q[TW-1]) begin
                        state_q <= RX_IDLE;
                    end else if (rise_i) begin
                        tbit_q  <= cnt_q[CNT_W-1:0];
                        idx_q   <= '0;
                        bad_q   <= 1'b0;
                        state_q <= RX_DATA;
                    end
                end
                RX_DATA: begin
                    if (timeout) begin
                        state_q <= RX_IDLE;
                        idx_q   <= '0;
                        bad_q   <= 1'b0;
                        if (idx_q != '0) begin
                            valid_o <= 1'b1;
                            err_o   <= 1'b1;
                            data_o  <= '0;
                        end
                    end else if (fall_i) begin
                        if (idx_q == LAST_IDX) begin
                            valid_o <= 1'b1;
                            data_o  <= {sh_q[DATA_W-2:0], bit_one};
                            err_o   <= bad_q | too_short | too_long;
                            idx_q   <= '0;
                            bad_q   <= 1'b0;
                        end else begin
                            sh_q  <= {sh_q[DATA_W-2:0], bit_one};
                            idx_q <= idx_q + IDX_W'(1);
                            bad_q <= bad_q | too_short | too_long;
                        end
                    end
                end
                default: state_q <= RX_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/pwb_link.sv
// Top of the pulse-width bit codec: sender, wire conditioning and receiver.
// Assumes: bit_period >= 20 at each burst start; line_in is asynchronous.
module pwb_link #(
    parameter int DATA_W      = 8,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  bit_period,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              tx_valid,
    output logic              tx_ready,
    output logic              line_drv,
    input  logic              line_in,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              rx_err
);
    logic wire_rise;
    logic wire_fall;

    pwb_tx #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_tx (
        .clk      (clk),
        .rst_n    (rst_n),
        .period_i (bit_period),
        .data_i   (tx_data),
        .valid_i  (tx_valid),
        .ready_o  (tx_ready),
        .drive_o  (line_drv)
    );

    pwb_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_i  (line_in),
        .rise_o (wire_rise),
        .fall_o (wire_fall)
    );

    pwb_rx #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .rise_i  (wire_rise),
        .fall_i  (wire_fall),
        .data_o  (rx_data),
        .valid_o (rx_valid),
        .err_o   (rx_err)
    );

endmodule

// File: rtl/pwb_link_chk.sv
// Temporal checks for pwb_link, attached by bind below.
// Assumes: bit_period >= 20 whenever a burst starts.
module pwb_link_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tx_valid,
    input logic             tx_ready,
    input logic             line_drv,
    input logic             rx_valid,
    input logic             tx_busy,
    input logic             rx_locked,
    input logic [CNT_W-1:0] tx_per,
    input logic [CNT_W-1:0] rx_tbit
);
    // R5: an accepted byte keeps the sender busy on the next clock.
    p_busy_after_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_ready) |=> !tx_ready);

    // R11: byte delivery is a single-cycle pulse.
    p_valid_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R2: even the shortest (logic 0) high time spans more than one clock.
    p_min_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(line_drv) |=> line_drv);

    // R3: the captured send period does not move during a burst.
    p_period_held_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_busy && $past(tx_busy)) |-> $stable(tx_per));

    // R6: the measured period is held while locked on data.
    p_tbit_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_locked && $past(rx_locked)) |-> $stable(rx_tbit));

endmodule

bind pwb_link pwb_link_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .tx_valid  (tx_valid),
    .tx_ready  (tx_ready),
    .line_drv  (line_drv),
    .rx_valid  (rx_valid),
    .tx_busy   (u_tx.state_q != pwb_pkg::TX_IDLE),
    .rx_locked (u_rx.state_q == pwb_pkg::RX_DATA),
    .tx_per    (u_tx.per_q),
    .rx_tbit   (u_rx.tbit_q)
);

// File: tb/pwb_link_bench.sv
// Self-checking bench: loopback sweeps of the sender and receiver, plus
// direct wire stimulus for decode thresholds, timeout and glitch rejection.
module pwb_link_bench;
    localparam int DW = 8;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [CW-1:0] cfg = CW'(20);
    logic [DW-1:0] tx_data = '0;
    logic          tx_valid = 1'b0;
    logic          tx_ready;
    logic          line_drv;
    logic          loop_sel = 1'b1;
    logic          bench_line = 1'b0;
    logic [DW-1:0] rx_data;
    logic          rx_valid;
    logic          rx_err;
    wire           line_in = loop_sel ? line_drv : bench_line;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwb_link #(.DATA_W(DW), .CNT_W(CW)) u_pwb_link (
        .clk        (clk),
        .rst_n      (rst_n),
        .bit_period (cfg),
        .tx_data    (tx_data),
        .tx_valid   (tx_valid),
        .tx_ready   (tx_ready),
        .line_drv   (line_drv),
        .line_in    (line_in),
        .rx_data    (rx_data),
        .rx_valid   (rx_valid),
        .rx_err     (rx_err)
    );

    // Capture of delivered bytes.
    logic [7:0] rx_byte [0:511];
    bit         rx_flag [0:511];
    int         n_rx = 0;
    always @(negedge clk) begin
        if (rst_n && rx_valid) begin
            if (n_rx < 512) begin
                rx_byte[n_rx] = rx_data;
                rx_flag[n_rx] = rx_err;
            end
            n_rx++;
        end
    end

    // Sender waveform monitor: high widths and rise-to-rise spacing.
    int hw [0:4095];
    int rr [0:4095];
    int n_rise = 0, n_fall = 0, cyc = 0, last_rise = 0;
    bit mon_prev = 1'b0;
    always @(negedge clk) begin
        cyc++;
        if (line_drv && !mon_prev) begin
            if (n_rise > 0 && n_rise <= 4096) rr[n_rise-1] = cyc - last_rise;
            last_rise = cyc;
            n_rise++;
        end
        if (!line_drv && mon_prev) begin
            if (n_fall < 4096) hw[n_fall] = cyc - last_rise;
            n_fall++;
        end
        mon_prev = line_drv;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        n_rise = 0;
        n_fall = 0;
        n_rx   = 0;
    endtask

    logic [7:0] exp_b [0:511];

    // Send n bytes as one back-to-back burst at period p, then verify.
    task automatic send_burst(input int p, input int n, input int base, input int step);
        int hi1, hi0, b;
        hi1 = (p * 7) / 10;
        hi0 = (p * 3) / 10;
        cfg = CW'(p);
        clear_mon();
        for (int k = 0; k < n; k++) begin
            exp_b[k] = 8'(base + k * step);
            tx_data  = exp_b[k];
            tx_valid = 1'b1;
            while (!tx_ready) @(negedge clk);
            @(negedge clk);
            if (k == 0) begin
                check(!tx_ready, "R5 ready low while shifting", int'(tx_ready), 0);
                cfg = CW'(p + 7);  // R3: must not affect this burst
            end
        end
        tx_valid = 1'b0;
        while (!tx_ready) @(negedge clk);
        repeat (3 * p + 20) @(negedge clk);
        check(n_rx == n, "R6 loopback byte count", n_rx, n);
        for (int k = 0; k < n; k++) begin
            check(rx_byte[k] == exp_b[k], "R4 loopback byte", int'(rx_byte[k]), int'(exp_b[k]));
            check(!rx_flag[k], "R7 loopback no error", int'(rx_flag[k]), 0);
        end
        check(n_fall == n * 8 + 1, "R3 pulse count", n_fall, n * 8 + 1);
        check(hw[0] == hi0, "R3 negotiation high", hw[0], hi0);
        for (int j = 0; j < n * 8; j++) begin
            b = int'(exp_b[j / 8][7 - (j % 8)]);
            if (b != 0) check(hw[j+1] == hi1, "R1 one high time", hw[j+1], hi1);
            else        check(hw[j+1] == hi0, "R2 zero high time", hw[j+1], hi0);
            check(rr[j] == p, "R3 rise spacing", rr[j], p);
        end
    endtask

    // Drive one bit period of t clocks with h high clocks, optional glitch.
    task automatic drive_bit(input int h, input int t, input bit glitch);
        for (int c = 0; c < t; c++) begin
            bench_line = (c < h) || (glitch && c == h + (t - h) / 2);
            @(negedge clk);
        end
        bench_line = 1'b0;
    endtask

    int frame_hi [0:7];

    task automatic send_frame(input int t, input int nbits, input int glitch_at);
        drive_bit((t * 3) / 10, t, 1'b0);
        for (int j = 0; j < nbits; j++) drive_bit(frame_hi[j], t, j == glitch_at);
        bench_line = 1'b0;
        repeat (3 * t + 10) @(negedge clk);
    endtask

    // Sweep the MSB high time across all legal-to-illegal values at period t.
    task automatic sweep_rx(input int t, input int lo, input int hi);
        bit eb, ee;
        for (int h = lo; h <= hi; h++) begin
            clear_mon();
            frame_hi[0] = h;
            for (int j = 1; j < 8; j++) frame_hi[j] = (t * 3) / 10;
            send_frame(t, 8, -1);
            eb = (2 * h) > t;
            ee = (5 * h < t) || (5 * h > 4 * t);
            check(n_rx == 1, "R6 one byte per frame", n_rx, 1);
            check(rx_byte[0] == {eb, 7'b0}, "R6 threshold decode", int'(rx_byte[0]), int'({eb, 7'b0}));
            check(rx_flag[0] == ee, "R7 window error", int'(rx_flag[0]), int'(ee));
        end
    endtask

    initial begin
        repeat (5) @(negedge clk);
        // R10: reset values.
        check(line_drv == 1'b0, "R10 line_drv in reset", int'(line_drv), 0);
        check(tx_ready == 1'b1, "R10 tx_ready in reset", int'(tx_ready), 1);
        check(rx_valid == 1'b0, "R10 rx_valid in reset", int'(rx_valid), 0);
        check(rx_err == 1'b0, "R10 rx_err in reset", int'(rx_err), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // Loopback: every byte value at the minimum period, then others.
        send_burst(20, 256, 0, 1);
        send_burst(23, 16, 8'hA5, 37);
        send_burst(37, 8, 8'h3C, 91);
        send_burst(64, 4, 8'hFF, 1);
        send_burst(41, 1, 8'h80, 0);

        // Direct wire stimulus.
        loop_sel = 1'b0;
        repeat (5) @(negedge clk);
        sweep_rx(40, 6, 34);
        sweep_rx(25, 3, 22);

        // R8: byte cut short after three bits.
        clear_mon();
        frame_hi[0] = 28; frame_hi[1] = 12; frame_hi[2] = 28;
        send_frame(40, 3, -1);
        check(n_rx == 1, "R8 truncated byte reported", n_rx, 1);
        check(rx_flag[0] == 1'b1, "R8 truncated error flag", int'(rx_flag[0]), 1);
        check(rx_byte[0] == 8'h00, "R8 truncated data zero", int'(rx_byte[0]), 0);

        // R9: lone one-clock pulse on an idle wire is ignored.
        clear_mon();
        bench_line = 1'b1;
        @(negedge clk);
        bench_line = 1'b0;
        repeat (60) @(negedge clk);
        check(n_rx == 0, "R9 idle glitch ignored", n_rx, 0);

        // R9: one-clock pulse inside a low phase does not disturb decode.
        for (int j = 0; j < 8; j++) frame_hi[j] = ((8'h5A >> (7 - j)) & 1) != 0 ? 21 : 9;
        send_frame(30, 8, 3);
        check(n_rx == 1, "R9 frame after glitches", n_rx, 1);
        check(rx_byte[0] == 8'h5A, "R9 glitch-free decode", int'(rx_byte[0]), 8'h5A);
        check(rx_flag[0] == 1'b0, "R9 no error from glitch", int'(rx_flag[0]), 0);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual %0d expected %0d", 0, 1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule